// File: doc/BRIEF.md
# Multi-Channel Light-Dimming PWM Bank

This block produces several pulse-width modulated outputs for driving light intensity. A pool of four free-running period counters serves as time bases. The channels form two equal groups. The fast group's counters advance on every clock. The slow group's counters advance once every `LS_DIV` clocks. Each channel picks one of its group's two counters and drives its output high while that counter is below the channel's effective duty.

Each channel holds its duty as an integer part and a 4-bit fraction. A per-channel accumulator spreads the fraction over successive periods, so the average high time matches the fractional setting. A per-channel fade engine can walk the duty up or down by a fixed step every N periods for a set number of steps, and it raises a done flag when the walk ends. Software reaches all settings through one write-only register port. Every duty or counter choice is applied only at the channel's own period boundary.

Top module: `pwm_bank`

## Requirements
- R1: After a synchronous active-low reset, every `pwm_out` bit and every `fade_done` bit is 0.
- R2: A channel's output is high exactly while its selected counter is below its effective duty. A duty of 0 gives a constant low, and a duty at or above the counter's period gives a constant high.
- R3: Counters count from 0 to period-1 and then wrap. Channels 0 and 1 use counters 0 and 1, which advance every clock. Channels 2 and 3 use counters 2 and 3, which advance once every `LS_DIV` clocks. Select value 0 picks the lower counter of the group and 1 picks the upper one.
- R4: With integer duty I and fraction F (in sixteenths), any run of 16 consecutive periods contains exactly 16*I+F high cycles.
- R5: A duty or counter-select write takes effect at the next period boundary of the channel's currently selected counter. Until then the output keeps its old waveform.
- R6: A fade moves the integer duty by `step` once every `pps` periods (0 is treated as 1), for `count` steps. Direction bit 1 counts up and 0 counts down. The fraction is kept.
- R7: A fade never drives the duty below 0. It never drives it above the selected counter's period.
- R8: A channel's `fade_done` flag sets when the fade's remaining step count reaches zero. A fade started with a count of zero sets it at once. The flag clears when a new fade start is written.
- R9: Register map, selected by `wr_addr[3:2]` with the index in `wr_addr[1:0]`:
  - Code 0 sets a counter's period in `wr_data[7:0]`.
  - Code 1 sets a channel. The duty goes in `wr_data[11:0]`, integer in bits 11:4 and fraction in bits 3:0. The select goes in bit 16.
  - Code 2 starts a fade. The direction goes in bit 0, the step in bits 15:8, `pps` in bits 23:16 and the count in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (code and index) |
| wr_data | input | 32 | Register write data |
| pwm_out | output | 4 | Per-channel PWM outputs |
| fade_done | output | 4 | Per-channel fade completion flags |

## Verification
The compare function is tried with several integer duties:
- Zero, a mid value, exactly the period, and above the period. These separate the two constant levels from normal pulsing.
- Two fractional duties. One of them forces full-high periods on its carry cycles, which exposes an accumulator that drops or misplaces the carry.
- Both counters of each group. These show the select and the slower group's advance rate.

For the glitch-free update, the bench writes a larger duty late in a period and checks that the output stays low until the wrap. Fades are run upward, downward, into both clamps and with `pps` of 2. A wrong step cadence, a missing clamp or a wrapped duty would each show in the measured high counts.

// File: rtl/pwm_pkg.sv
// Package: shared register codes and field positions for the PWM bank.
// Assumes a 32-bit write data word and 8-bit fade fields.
package pwm_pkg;
    typedef enum logic [1:0] {
        REG_PERIOD = 2'd0,
        REG_CHAN   = 2'd1,
        REG_FADE   = 2'd2,
        REG_NONE   = 2'd3
    } reg_code_e;

    localparam int DATA_W     = 32;
    localparam int FADE_W     = 8;
    localparam int SEL_BIT    = 16;
    localparam int F_DIR_BIT  = 0;
    localparam int F_STEP_LSB = 8;
    localparam int F_PPS_LSB  = 16;
    localparam int F_CNT_LSB  = 24;
endpackage

// File: rtl/pwm_timer.sv
// Module: one period counter. It counts 0..period-1 on each tick and then wraps.
// Assumes the period may change at any time. A count at or past the new limit
// wraps on the next tick. A period of 0 or 1 wraps on every tick.
module pwm_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    // End of period: the next tick returns the count to zero.
    assign wrap = tick && (({1'b0, cnt} + 1'b1) >= {1'b0, period});

    // Advance or wrap the count on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1));
    a_r3_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/pwm_channel.sv
// Module: one PWM channel. It holds a shadowed duty and select, a fraction
// dither accumulator and a fade engine, and compares the selected counter
// against its effective duty. Every state change happens at the boundary
// of the selected counter, except fade start and the pending shadow load.
// Assumes the timer buses carry TPG counters of CW bits each.
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CW   = 8,
    parameter int FW   = 4,
    parameter int TPG  = 2,
    parameter int SELW = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TPG*CW-1:0] t_cnt,
    input  logic [TPG*CW-1:0] t_per,
    input  logic [TPG-1:0]    t_wrap,
    input  logic              duty_we,
    input  logic [CW+FW-1:0]  duty_wdata,
    input  logic [SELW-1:0]   sel_wdata,
    input  logic              fade_we,
    input  logic              fade_dir_in,
    input  logic [FADE_W-1:0] fade_step_in,
    input  logic [FADE_W-1:0] fade_pps_in,
    input  logic [FADE_W-1:0] fade_cnt_in,
    output logic              pwm,
    output logic              done
);
    localparam int DUTYW = CW + FW;
    localparam int SUMW  = ((CW > FADE_W) ? CW : FADE_W) + 1;

    logic [SELW-1:0]   sel_q, pend_sel;
    logic [DUTYW-1:0]  duty_q, pend_duty;
    logic              pend_v;
    logic [FW-1:0]     acc_q;
    logic [CW:0]       eff_q;
    logic              fade_act, fade_dir;
    logic [FADE_W-1:0] fade_step, fade_pps, fade_left, ppc_q;

    logic [CW-1:0]     cur_cnt, cur_per, base_int, stepped_int, next_int;
    logic [FW-1:0]     base_frac;
    logic [DUTYW-1:0]  base;
    logic              boundary, step_now;
    logic [FW:0]       acc_sum;
    logic [SUMW-1:0]   up_sum;

    // Pick the selected counter's state from the group buses.
    assign cur_cnt  = t_cnt[sel_q*CW +: CW];
    assign cur_per  = t_per[sel_q*CW +: CW];
    assign boundary = t_wrap[sel_q];

    // Compute the duty for the next period: the shadow value, then a fade step, then the dither carry.
    always_comb begin
        base        = pend_v ? pend_duty : duty_q;
        base_int    = base[DUTYW-1:FW];
        base_frac   = base[FW-1:0];
        step_now    = fade_act && (({1'b0, ppc_q} + 1'b1) >= {1'b0, fade_pps});
        up_sum      = SUMW'(base_int) + SUMW'(fade_step);
        if (fade_dir)
            stepped_int = (up_sum > SUMW'(cur_per)) ? cur_per : CW'(up_sum);
        else
            stepped_int = (SUMW'(base_int) < SUMW'(fade_step)) ? '0
                        : CW'(SUMW'(base_int) - SUMW'(fade_step));
        next_int    = step_now ? stepped_int : base_int;
        acc_sum     = {1'b0, acc_q} + {1'b0, base_frac};
    end

    // Shadow registers: hold a software write until the next boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_duty <= '0;
            pend_sel  <= '0;
        end else if (duty_we) begin
            pend_v    <= 1'b1;
            pend_duty <= duty_wdata;
            pend_sel  <= sel_wdata;
        end else if (boundary) begin
            pend_v    <= 1'b0;
        end
    end

    // Active state: at each boundary, update the duty, select, accumulator and effective duty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            sel_q  <= '0;
            acc_q  <= '0;
            eff_q  <= '0;
        end else if (boundary) begin
            duty_q <= {next_int, base_frac};
            sel_q  <= pend_v ? pend_sel : sel_q;
            acc_q  <= acc_sum[FW-1:0];
            eff_q  <= {1'b0, next_int} + (CW+1)'(acc_sum[FW]);
        end
    end

    // Fade engine: load on start, then count periods and steps at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fade_act  <= 1'b0;
            fade_dir  <= 1'b0;
            fade_step <= '0;
            fade_pps  <= '0;
            fade_left <= '0;
            ppc_q     <= '0;
            done      <= 1'b0;
        end else if (fade_we) begin
            fade_dir  <= fade_dir_in;
            fade_step <= fade_step_in;
            fade_pps  <= fade_pps_in;
            fade_left <= fade_cnt_in;
            ppc_q     <= '0;
            fade_act  <= (fade_cnt_in != '0);
            done      <= (fade_cnt_in == '0);
        end else if (boundary && fade_act) begin
            if (step_now) begin
                ppc_q     <= '0;
                fade_left <= fade_left - 1'b1;
                if (fade_left == FADE_W'(1)) begin
                    fade_act <= 1'b0;
                    done     <= 1'b1;
                end
            end else begin
                ppc_q <= ppc_q + 1'b1;
            end
        end
    end

    // Output compare: high while the counter is below the effective duty.
    assign pwm = ({1'b0, cur_cnt} < eff_q);

    a_r5_eff_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(eff_q));
    a_r5_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(sel_q));
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fade_we && fade_cnt_in != '0) |=> !done);
    a_r8_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!fade_we && boundary && step_now && fade_left == FADE_W'(1)) |=> done);
    a_r7_up_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!fade_we && !pend_v && boundary && step_now && fade_dir)
        |=> (duty_q[DUTYW-1:FW] >= $past(duty_q[DUTYW-1:FW])
             || duty_q[DUTYW-1:FW] == $past(cur_per)));
    a_r7_down_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!fade_we && !pend_v && boundary && step_now && !fade_dir)
        |=> (duty_q[DUTYW-1:FW] <= $past(duty_q[DUTYW-1:FW])));
endmodule

// File: rtl/pwm_bank.sv
// Module: top of the PWM bank. It decodes the write port, holds the counter
// periods, generates the prescaler for the slow group, the counters and the
// channels. Assumes NTIMER and NCH are even. Half of each belongs to the fast
// group and half to the slow group.
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int CW     = 8,
    parameter int FW     = 4,
    parameter int NCH    = 4,
    parameter int NTIMER = 4,
    parameter int LS_DIV = 2,
    localparam int IDXW  = (NCH > NTIMER) ? $clog2(NCH) : $clog2(NTIMER),
    localparam int AW    = IDXW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    fade_done
);
    localparam int TPG  = NTIMER / 2;
    localparam int CPG  = NCH / 2;
    localparam int SELW = (TPG > 1) ? $clog2(TPG) : 1;
    localparam int PSW  = $clog2(LS_DIV + 1);

    reg_code_e           code;
    logic [IDXW-1:0]     idx;
    logic [CW-1:0]       per_q [NTIMER];
    logic [CW-1:0]       t_cnt [NTIMER];
    logic [NTIMER-1:0]   t_wrap;
    logic [PSW-1:0]      ps_q;
    logic                slow_tick;
    logic                unused_bits;

    assign code = reg_code_e'(wr_addr[AW-1 -: 2]);
    assign idx  = wr_addr[IDXW-1:0];
    assign unused_bits = ^{wr_data[DATA_W-1:SEL_BIT+SELW], wr_data[SEL_BIT-1:CW+FW],
                           wr_data[F_STEP_LSB-1:F_DIR_BIT+1]};

    // Period registers: written directly and used by the counters at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTIMER; i++) per_q[i] <= '0;
        end else if (wr_en && code == REG_PERIOD && int'(idx) < NTIMER) begin
            per_q[idx] <= wr_data[CW-1:0];
        end
    end

    // Prescaler: one slow-group tick every LS_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)         ps_q <= '0;
        else if (slow_tick) ps_q <= '0;
        else                ps_q <= ps_q + 1'b1;
    end
    assign slow_tick = (ps_q == PSW'(LS_DIV - 1));

    a_r3_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |=> (ps_q == '0));

    for (genvar t = 0; t < NTIMER; t++) begin : g_timer
        pwm_timer #(.CW(CW)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   ((t < TPG) ? 1'b1 : slow_tick),
            .period (per_q[t]),
            .cnt    (t_cnt[t]),
            .wrap   (t_wrap[t])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int GRP = c / CPG;
        logic [TPG*CW-1:0] bus_cnt, bus_per;
        logic [TPG-1:0]    bus_wrap;

        for (genvar k = 0; k < TPG; k++) begin : g_bus
            assign bus_cnt[k*CW +: CW] = t_cnt[GRP*TPG + k];
            assign bus_per[k*CW +: CW] = per_q[GRP*TPG + k];
            assign bus_wrap[k]         = t_wrap[GRP*TPG + k];
        end

        pwm_channel #(.CW(CW), .FW(FW), .TPG(TPG), .SELW(SELW)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .t_cnt        (bus_cnt),
            .t_per        (bus_per),
            .t_wrap       (bus_wrap),
            .duty_we      (wr_en && code == REG_CHAN && int'(idx) == c),
            .duty_wdata   (wr_data[CW+FW-1:0]),
            .sel_wdata    (wr_data[SEL_BIT +: SELW]),
            .fade_we      (wr_en && code == REG_FADE && int'(idx) == c),
            .fade_dir_in  (wr_data[F_DIR_BIT]),
            .fade_step_in (wr_data[F_STEP_LSB +: FADE_W]),
            .fade_pps_in  (wr_data[F_PPS_LSB +: FADE_W]),
            .fade_cnt_in  (wr_data[F_CNT_LSB +: FADE_W]),
            .pwm          (pwm_out[c]),
            .done         (fade_done[c])
        );
    end
endmodule

// File: tb/pwm_bank_bench.sv
// Bench: a scoreboard of expected high-cycle counts over windows. The driver
// pushes items and the monitor measures pwm_out over each window and compares.
// Windows are whole multiples of the output period, so the phase does not matter.
module pwm_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  pwm_out, fade_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        int    ch;
        int    cycles;
        int    exp_high;
        string tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    pwm_bank u_pwm_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .fade_done(fade_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] code, input logic [1:0] idx, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = {code, idx}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_chan(input int ch, input int dint, input int dfrac, input int sel);
        wr(2'd1, 2'(ch), (32'(sel) << 16) | (32'(dint) << 4) | 32'(dfrac));
    endtask

    task automatic fade(input int ch, input int dir, input int step, input int pps, input int cnt);
        wr(2'd2, 2'(ch), (32'(cnt) << 24) | (32'(pps) << 16) | (32'(step) << 8) | 32'(dir));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: push an expected window and wait until the monitor has judged it.
    task automatic expect_high(input int ch, input int cycles, input int exp, input string tag);
        sb_item_t it;
        it.ch = ch; it.cycles = cycles; it.exp_high = exp; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // Monitor: measure high cycles over each queued window.
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            begin
                sb_item_t it;
                int h;
                it = sb_q[0];
                h = 0;
                repeat (it.cycles) begin
                    @(negedge clk);
                    if (pwm_out[it.ch]) h++;
                end
                chk(h == it.exp_high, it.tag, h, it.exp_high);
                void'(sb_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk(pwm_out == 4'd0, "R1 outputs low after reset", int'(pwm_out), 0);
        chk(fade_done == 4'd0, "R1 done flags clear after reset", int'(fade_done), 0);

        // R9 period registers: counters 0..3.
        wr(2'd0, 2'd0, 32'd10);
        wr(2'd0, 2'd1, 32'd20);
        wr(2'd0, 2'd2, 32'd5);
        wr(2'd0, 2'd3, 32'd8);

        // R2 integer duties on channel 0, counter 0 (period 10).
        set_chan(0, 4, 0, 0);  idle(25);
        expect_high(0, 100, 40, "R2 R9 duty 4 of 10");
        set_chan(0, 0, 0, 0);  idle(25);
        expect_high(0, 100, 0, "R2 duty 0 constant low");
        set_chan(0, 10, 0, 0); idle(25);
        expect_high(0, 100, 100, "R2 duty equal period constant high");
        set_chan(0, 15, 0, 0); idle(25);
        expect_high(0, 100, 100, "R2 duty above period constant high");

        // R4 fractional dither over 16 periods.
        set_chan(0, 3, 5, 0);  idle(25);
        expect_high(0, 160, 53, "R4 duty 3+5/16");
        set_chan(0, 9, 15, 0); idle(25);
        expect_high(0, 160, 159, "R4 duty 9+15/16 carry to full");

        // R3 select the upper fast counter (period 20).
        set_chan(0, 5, 0, 1);  idle(45);
        expect_high(0, 200, 50, "R3 fast group select 1");

        // R3 slow group: counter 2 (period 5, 10 clocks), counter 3 (period 8, 16 clocks).
        set_chan(2, 2, 0, 0);  idle(30);
        expect_high(2, 100, 40, "R3 slow counter 2");
        set_chan(3, 2, 0, 1);  idle(40);
        expect_high(3, 160, 40, "R3 slow counter 3");

        // R5 a write late in a period is held until the wrap.
        set_chan(1, 4, 0, 0);  idle(25);
        while (pwm_out[1] !== 1'b0) @(negedge clk);
        while (pwm_out[1] !== 1'b1) @(negedge clk);
        idle(6);                            // counter at 6
        set_chan(1, 8, 0, 0);               // returns with counter at 7
        chk(pwm_out[1] == 1'b0, "R5 old duty until boundary", int'(pwm_out[1]), 0);
        idle(3);                            // counter at 0 of the new period
        chk(pwm_out[1] == 1'b1, "R5 new duty after boundary", int'(pwm_out[1]), 1);
        idle(7);                            // counter at 7
        chk(pwm_out[1] == 1'b1, "R5 new duty covers count 7", int'(pwm_out[1]), 1);

        // R6 R8 fade up 2 -> 8.
        set_chan(1, 2, 0, 0);  idle(25);
        fade(1, 1, 2, 1, 3);
        chk(fade_done[1] == 1'b0, "R8 done clear while fading", int'(fade_done[1]), 0);
        idle(50);
        chk(fade_done[1] == 1'b1, "R8 done set after steps", int'(fade_done[1]), 1);
        expect_high(1, 100, 80, "R6 fade up result");

        // R7 fade down into floor, done clears on start.
        fade(1, 0, 3, 1, 5);
        chk(fade_done[1] == 1'b0, "R8 done cleared by new start", int'(fade_done[1]), 0);
        idle(70);
        expect_high(1, 100, 0, "R7 fade clamps at 0");
        fade(1, 1, 1, 1, 1); idle(25);
        expect_high(1, 100, 10, "R7 no wrap below 0");

        // R7 ceiling at period.
        fade(1, 1, 7, 1, 3); idle(50);
        expect_high(1, 100, 100, "R7 fade up to period");
        fade(1, 0, 1, 1, 1); idle(25);
        expect_high(1, 100, 90, "R7 ceiling held at period");

        // R6 pps of 2: 9 -> 6 -> 3 across four periods.
        fade(1, 0, 3, 2, 2);
        idle(29);
        chk(fade_done[1] == 1'b0, "R6 pps 2 not done after 3 periods", int'(fade_done[1]), 0);
        idle(16);
        chk(fade_done[1] == 1'b1, "R6 pps 2 done after 4 periods", int'(fade_done[1]), 1);
        expect_high(1, 100, 30, "R6 pps 2 result");

        // R8 zero count sets done at once.
        fade(0, 1, 1, 1, 0);
        chk(fade_done[0] == 1'b1, "R8 zero count done at once", int'(fade_done[0]), 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule